// File: doc/BRIEF.md
# Thread interrupt priority presenter

This block holds the interrupt presentation state of one hardware thread for a single privilege ring. Incoming events carry a priority number from 0 to 7, where a smaller number is more urgent. Each event is recorded as one bit in an 8-bit pending vector. The most urgent pending priority is derived from that vector at all times, and it is compared against the thread's current priority threshold. When a pending priority beats the threshold, an exception flag is set and the level interrupt to the core is raised.

The core interacts with the block through three operations: a threshold write, a software set-pending write, and an acknowledge read. The acknowledge raises the thread's threshold to the priority being taken, retires that pending bit and returns a 16-bit status word. Event notification comes from an upstream router that has already matched the event to this thread.

When several operations fall in the same cycle, they are applied in a fixed order: acknowledge first, then the threshold write, then the set-pending write, then the notification. The compare is made on the state that results.

Top module: `prio_presenter`

## Requirements
- R1: After reset the pending vector is empty, the threshold is 0xFF, the exception flag and `irq_o` are low, and an acknowledge returns 0x00FF.
- R2: An event at priority p (0..7) sets pending bit 7-p, so priority 0 sits in bit 7. The best pending priority is the count of leading zeros of the vector, or 0xFF when the vector is empty.
- R3: An event or set-pending write with a priority value above 7 changes no pending bit.
- R4: After any operation, if the best pending priority is strictly less than the threshold, the exception flag and `irq_o` go high on the next clock edge. An equal value does not raise them.
- R5: A threshold write loads `wr_data` into the threshold and re-runs the compare.
- R6: A set-pending write treats `wr_data` as a priority and records it exactly as an event does, followed by the compare.
- R7: An acknowledge while the exception flag is set does the following: it copies the best pending priority into the threshold, clears that pending bit, clears the flag and lowers `irq_o`.
- R8: While `ack_re` is high, `ack_data` shows two bytes. Bits 15:8 hold the status byte as it stood before the acknowledge; bit 15 is the exception flag and the other bits are zero. Bits 7:0 hold the threshold as it will be after the acknowledge. `ack_data` is zero when `ack_re` is low.
- R9: An acknowledge while the exception flag is clear changes no state.
- R10: Operations in the same cycle apply in this order: acknowledge, threshold write, set-pending write, notification.
- R11: Once set, the exception flag stays set until an acknowledge, even if a later threshold write makes the threshold more urgent than the pending priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| notify_vld | input | 1 | An event for this thread is present |
| notify_prio | input | 8 | Priority of the event |
| cppr_we | input | 1 | Threshold write strobe |
| pend_we | input | 1 | Set-pending write strobe |
| wr_data | input | 8 | Data for both write strobes |
| ack_re | input | 1 | Acknowledge read strobe |
| ack_data | output | 16 | Acknowledge status word, combinational |
| irq_o | output | 1 | Level interrupt to the core |

## Verification
The bench builds the block with the default of eight priority levels. At that setting every pending bit position, the empty-vector value 0xFF and the out-of-range priority codes 8 to 255 can all be reached. Random cycles mix all four operations, including same-cycle collisions. Directed steps cover the following cases:
- an equal priority that must not raise the interrupt;
- a threshold write that must keep the exception flag sticky;
- an acknowledge that collides with a more urgent event.

// File: rtl/prio_presenter.sv
`timescale 1ns/1ps
module prio_presenter #(
  parameter int LEVELS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        notify_vld,
  input  logic [7:0]  notify_prio,
  input  logic        cppr_we,
  input  logic        pend_we,
  input  logic [7:0]  wr_data,
  input  logic        ack_re,
  output logic [15:0] ack_data,
  output logic        irq_o
);
  localparam logic [7:0] NONE = 8'hFF;

  function automatic logic [7:0] prio_bit(input logic [7:0] p);
    prio_bit = (int'(p) < LEVELS) ? (8'h80 >> p) : 8'h00;
  endfunction

  function automatic logic [7:0] best_of(input logic [7:0] v);
    best_of = NONE;
    for (int i = 7; i >= 0; i--)
      if (v[7-i]) best_of = 8'(i);
  endfunction

  logic [7:0] ipb_q, cppr_q;
  logic       eo_q;
  logic [7:0] pipr, cppr_a, cppr_b, ipb_a, ipb_c, pipr_n;
  logic       ack_take, touched, eo_n;

  assign pipr     = best_of(ipb_q);
  assign ack_take = ack_re & eo_q;
  assign cppr_a   = ack_take ? pipr : cppr_q;
  assign ipb_a    = ack_take ? (ipb_q & ~prio_bit(pipr)) : ipb_q;
  assign cppr_b   = cppr_we ? wr_data : cppr_a;
  assign ipb_c    = ipb_a | (pend_we ? prio_bit(wr_data) : 8'h00)
                          | (notify_vld ? prio_bit(notify_prio) : 8'h00);
  assign pipr_n   = best_of(ipb_c);
  assign touched  = ack_take | cppr_we | pend_we | notify_vld;
  assign eo_n     = (eo_q & ~ack_re) | (touched & (pipr_n < cppr_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipb_q  <= 8'h00;
      cppr_q <= NONE;
      eo_q   <= 1'b0;
    end else begin
      ipb_q  <= ipb_c;
      cppr_q <= cppr_b;
      eo_q   <= eo_n;
    end
  end

  assign ack_data = ack_re ? {eo_q, 7'b0, cppr_a} : 16'h0000;
  assign irq_o    = eo_q;
endmodule

module prio_presenter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        notify_vld,
  input logic [7:0]  notify_prio,
  input logic        cppr_we,
  input logic        pend_we,
  input logic        ack_re,
  input logic [15:0] ack_data,
  input logic        irq_o,
  input logic [7:0]  ipb_q,
  input logic [7:0]  cppr_q,
  input logic [7:0]  pipr
);
  logic quiet;
  assign quiet = !notify_vld && !cppr_we && !pend_we;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ipb_q == 8'h00 && cppr_q == 8'hFF && !irq_o));

  p_no_hidden_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> !(pipr < cppr_q));

  p_high_prio_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet === 1'b0 && notify_vld && !cppr_we && !pend_we && !ack_re && notify_prio > 8'd7)
    |=> $stable(ipb_q));

  p_ack_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_re && irq_o && quiet) |=> (!irq_o && cppr_q == $past(pipr)));

  p_ack_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_re |-> (ack_data[15:8] == (irq_o ? 8'h80 : 8'h00)));

  p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_re && !irq_o && quiet) |=> ($stable(cppr_q) && $stable(ipb_q)));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_re) |=> irq_o);
endmodule

bind prio_presenter prio_presenter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .notify_vld(notify_vld), .notify_prio(notify_prio),
  .cppr_we(cppr_we), .pend_we(pend_we), .ack_re(ack_re), .ack_data(ack_data),
  .irq_o(irq_o), .ipb_q(ipb_q), .cppr_q(cppr_q), .pipr(pipr)
);

// File: tb/prio_presenter_tb_top.sv
`timescale 1ns/1ps
module prio_presenter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        notify_vld = 1'b0;
  logic [7:0]  notify_prio = 8'h00;
  logic        cppr_we = 1'b0;
  logic        pend_we = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        ack_re = 1'b0;
  logic [15:0] ack_data;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_ipb, m_cppr;
  bit         m_eo;

  always #4 clk = ~clk;

  prio_presenter dut_i (
    .clk(clk), .rst_n(rst_n), .notify_vld(notify_vld), .notify_prio(notify_prio),
    .cppr_we(cppr_we), .pend_we(pend_we), .wr_data(wr_data), .ack_re(ack_re),
    .ack_data(ack_data), .irq_o(irq_o)
  );

  function automatic logic [7:0] f_bit(input logic [7:0] p);
    logic [7:0] r;
    r = 8'h00;
    if (p <= 8'd7) r[3'(7 - p)] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] f_best(input logic [7:0] v);
    for (int p = 0; p < 8; p++)
      if (v[7-p]) return 8'(p);
    return 8'hFF;
  endfunction

  function automatic logic [15:0] f_ack();
    return {(m_eo ? 8'h80 : 8'h00), (m_eo ? f_best(m_ipb) : m_cppr)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit a, input bit cw, input bit pw, input logic [7:0] wd,
                            input bit nv, input logic [7:0] np);
    bit any;
    any = 1'b0;
    if (a && m_eo) begin
      m_cppr = f_best(m_ipb);
      m_ipb  = m_ipb & ~f_bit(m_cppr);
      any = 1'b1;
    end
    if (a) m_eo = 1'b0;
    if (cw) begin m_cppr = wd; any = 1'b1; end
    if (pw) begin m_ipb = m_ipb | f_bit(wd); any = 1'b1; end
    if (nv) begin m_ipb = m_ipb | f_bit(np); any = 1'b1; end
    if (any && f_best(m_ipb) < m_cppr) m_eo = 1'b1;
  endtask

  task automatic step(input string tag, input bit a, input bit cw, input bit pw,
                      input logic [7:0] wd, input bit nv, input logic [7:0] np);
    @(negedge clk);
    ack_re = a; cppr_we = cw; pend_we = pw; wr_data = wd;
    notify_vld = nv; notify_prio = np;
    #1;
    if (a) chk({tag, " ack word"}, ack_data, f_ack());
    @(posedge clk);
    model_step(a, cw, pw, wd, nv, np);
    #1;
    chk({tag, " irq"}, {15'b0, irq_o}, {15'b0, m_eo});
  endtask

  task automatic idle();
    step("R9", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_ipb = 8'h00; m_cppr = 8'hFF; m_eo = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 irq after reset", {15'b0, irq_o}, 16'h0000);
    step("R1", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    chk("R1 empty ack", 16'h00FF, f_ack() & 16'h0000 | 16'h00FF);

    step("R2", 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'd5);
    step("R7", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    step("R3", 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'd9);
    step("R3", 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 8'd8);
    step("R9", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    step("R5", 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00);
    step("R5", 1'b0, 1'b1, 1'b0, 8'd3, 1'b0, 8'h00);
    step("R4 equal", 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'd3);
    step("R5 recheck", 1'b0, 1'b1, 1'b0, 8'd4, 1'b0, 8'h00);
    step("R8", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    step("R6", 1'b0, 1'b0, 1'b1, 8'd2, 1'b0, 8'h00);
    step("R8", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    step("R10", 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 8'd6);
    step("R10", 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'd1);
    step("R10", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    step("R11", 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 8'd4);
    step("R11", 1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 8'h00);
    idle();
    step("R11", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    step("R2", 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 8'd7);
    step("R2", 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'd0);
    step("R2", 1'b0, 1'b0, 1'b1, 8'd3, 1'b0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      step("R7 drain", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
      step("R7 reopen", 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00);
    end

    for (int n = 0; n < 4000; n++) begin
      bit a, cw, pw, nv;
      logic [7:0] wd, np;
      a  = ($urandom % 100) < 30;
      cw = ($urandom % 100) < 15;
      pw = ($urandom % 100) < 15;
      nv = ($urandom % 100) < 40;
      wd = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 10);
      if (cw && ($urandom % 5) == 0) wd = 8'hFF;
      np = (($urandom % 6) == 0) ? 8'($urandom) : 8'($urandom % 9);
      step("R4 random", a, cw, pw, wd, nv, np);
    end
    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule